// File: doc/BRIEF.md
# Transport Stream Sync Lock Detector

This block sits after the inner decoder and watches the byte stream for packet boundaries. It hunts through the stream one valid byte at a time for a sync byte. Once it finds one, it checks that further sync bytes follow at the spacing of one coded packet. After enough aligned hits it declares lock. It then keeps checking the sync position of every packet. It gives up lock after a run of bad sync words whose length comes from a 2-bit control field.

While locked, the block marks each packet start. It raises single-cycle pulses when lock is gained or lost. Each pulse also sets a sticky interrupt bit, which stays set until a clear strobe. The bytes themselves pass through untouched. A bypass control switches the detection off completely, and the stream still flows through.

Top module: `ts_sync_lock`

## Requirements
- R1: A valid byte counts as a sync word when it equals the active pattern or its bitwise inverse. The active pattern is 0x47 when `prog_sync_en` is 0, and `prog_sync_val` when `prog_sync_en` is 1.
- R2: While hunting, every valid byte is examined. The first sync word found starts verification. Cycles with `in_valid` low neither advance the packet position nor count as bytes.
- R3: The sync position repeats every 204 valid bytes. Lock is declared on the third consecutive aligned sync word. A non-sync byte at an expected position during verification returns the block to hunting.
- R4: While locked, lock is dropped on the (`loss_sel` + 2)-th consecutive non-sync byte at an aligned position. With `loss_sel` = 3 this is the 5th bad word; with `loss_sel` = 0 it is the 2nd.
- R5: While locked, a good sync word at an aligned position resets the run of bad sync words to zero.
- R6: `pkt_start` is high, in the same cycle as the byte, for exactly the valid byte at each aligned sync position while `locked` is high. It is low for every other byte.
- R7: `lock_gain` and `lock_lost` each pulse for one cycle, in the cycle after the byte that changed the lock state. `locked` changes in that same cycle.
- R8: `irq_gain` and `irq_lost` are set by the corresponding event and stay set until `irq_clr` is high for a cycle. Both are 0 after reset.
- R9: While `bypass` is high, `locked` is forced low within one cycle, detection restarts from hunting, and no `pkt_start`, `lock_gain` or `lock_lost` pulse is produced.
- R10: `out_byte` and `out_valid` always equal `in_byte` and `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_byte | input | 8 | Byte from the inner decoder |
| in_valid | input | 1 | Byte qualifier |
| loss_sel | input | 2 | Loss run length minus two |
| prog_sync_en | input | 1 | Use the programmed sync byte |
| prog_sync_val | input | 8 | Programmed sync byte |
| bypass | input | 1 | Disable detection |
| irq_clr | input | 1 | Clear both interrupt bits |
| out_byte | output | 8 | Byte passed through |
| out_valid | output | 1 | Qualifier passed through |
| locked | output | 1 | Lock status |
| pkt_start | output | 1 | Marks the aligned sync byte while locked |
| lock_gain | output | 1 | One-cycle lock acquired event |
| lock_lost | output | 1 | One-cycle lock lost event |
| irq_gain | output | 1 | Sticky lock acquired flag |
| irq_lost | output | 1 | Sticky lock lost flag |

## Verification
The assertions assume that `loss_sel`, `prog_sync_en` and `prog_sync_val` are held steady while a lock is being acquired or held. They also assume `bypass` is low at the first clock after reset. The stimulus changes these controls only inside a reset, or while the block is bypassed. Bytes are driven on the falling edge. Filler bytes are 0x00, which never matches any pattern in use, so the only sync words the detector can see are the ones the bench places at packet starts.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCK   = 2'd2
  } sync_state_e;

  // Length of the bad-word run that ends lock.
  function automatic logic [2:0] loss_limit(input logic [1:0] sel);
    return {1'b0, sel} + 3'd2;
  endfunction

  // True when a byte is the pattern or its complement.
  function automatic logic sync_hit(input logic [BYTE_W-1:0] b,
                                    input logic [BYTE_W-1:0] pat);
    return (b == pat) || (b == ~pat);
  endfunction
endpackage

// File: rtl/ts_sync_match.sv
module ts_sync_match
  import ts_sync_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEF_SYNC = 8'h47
) (
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              prog_en,
  input  logic [BYTE_W-1:0] prog_val,
  output logic              hit
);
  logic [BYTE_W-1:0] pattern;

  always_comb begin
    pattern = prog_en ? prog_val : DEF_SYNC;
    hit     = sync_hit(in_byte, pattern);
  end
endmodule

// File: rtl/ts_sync_pos.sv
module ts_sync_pos #(
  parameter int PKT_LEN = 204
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic restart,
  input  logic tracking,
  output logic aligned
);
  localparam int PW = $clog2(PKT_LEN + 1);
  localparam logic [PW-1:0] LAST = PW'(PKT_LEN);
  localparam logic [PW-1:0] FIRST = PW'(1);

  logic [PW-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= FIRST;
    else if (restart) pos <= FIRST;
    else if (adv && tracking) pos <= (pos == LAST) ? FIRST : pos + FIRST;
  end

  assign aligned = tracking && (pos == LAST);

  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos >= FIRST) && (pos <= LAST));
endmodule

// File: rtl/ts_sync_fsm.sv
module ts_sync_fsm
  import ts_sync_pkg::*;
#(
  parameter int ACQ_COUNT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       hit,
  input  logic       aligned,
  input  logic       bypass,
  input  logic [1:0] loss_sel,
  output logic       locked,
  output logic       tracking,
  output logic       restart,
  output logic       pkt_start,
  output logic       gain_evt,
  output logic       lost_evt,
  output logic       gain_q,
  output logic       lost_q
);
  localparam int GW = $clog2(ACQ_COUNT + 1);
  localparam logic [GW-1:0] ACQ_LAST = GW'(ACQ_COUNT);
  localparam logic [GW-1:0] G_ONE = GW'(1);

  sync_state_e state, nxt_state;
  logic [GW-1:0] good_cnt, nxt_good;
  logic [2:0]    bad_cnt, nxt_bad;

  always_comb begin
    nxt_state = state;
    nxt_good  = good_cnt;
    nxt_bad   = bad_cnt;
    gain_evt  = 1'b0;
    lost_evt  = 1'b0;
    if (bypass) begin
      nxt_state = ST_HUNT;
      nxt_good  = '0;
      nxt_bad   = '0;
    end else if (in_valid) begin
      unique case (state)
        ST_HUNT: if (hit) begin
          nxt_state = ST_VERIFY;
          nxt_good  = G_ONE;
        end
        ST_VERIFY: if (aligned) begin
          if (!hit) begin
            nxt_state = ST_HUNT;
            nxt_good  = '0;
          end else if (good_cnt + G_ONE == ACQ_LAST) begin
            nxt_state = ST_LOCK;
            nxt_good  = '0;
            nxt_bad   = '0;
            gain_evt  = 1'b1;
          end else begin
            nxt_good = good_cnt + G_ONE;
          end
        end
        ST_LOCK: if (aligned) begin
          if (hit) begin
            nxt_bad = '0;
          end else if (bad_cnt + 3'd1 >= loss_limit(loss_sel)) begin
            nxt_state = ST_HUNT;
            nxt_bad   = '0;
            lost_evt  = 1'b1;
          end else begin
            nxt_bad = bad_cnt + 3'd1;
          end
        end
        default: nxt_state = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HUNT;
      good_cnt <= '0;
      bad_cnt  <= '0;
      gain_q   <= 1'b0;
      lost_q   <= 1'b0;
    end else begin
      state    <= nxt_state;
      good_cnt <= nxt_good;
      bad_cnt  <= nxt_bad;
      gain_q   <= gain_evt;
      lost_q   <= lost_evt;
    end
  end

  assign locked    = (state == ST_LOCK);
  assign tracking  = (state != ST_HUNT);
  assign restart   = (state == ST_HUNT) && in_valid && hit && !bypass;
  assign pkt_start = locked && in_valid && aligned && !bypass;

  // R7
  gain_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> gain_q);
  // R7
  events_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gain_q && lost_q));
  // R4
  lost_from_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q |-> (!locked && $past(locked)));
  // R9
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bypass) |-> (!locked && !gain_q && !lost_q));
  // R6
  pstart_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> locked);
endmodule

// File: rtl/ts_sync_irq.sv
module ts_sync_irq #(
  parameter int N_EV = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] ev,
  input  logic [N_EV-1:0] ev_q,
  input  logic            clr,
  output logic [N_EV-1:0] irq
);
  for (genvar i = 0; i < N_EV; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq[i] <= 1'b0;
      else if (ev[i]) irq[i] <= 1'b1;
      else if (clr) irq[i] <= 1'b0;
    end

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_q[i] |-> irq[i]);
    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[i]) |-> $past(clr));
  end
endmodule

// File: rtl/ts_sync_lock.sv
module ts_sync_lock
  import ts_sync_pkg::*;
#(
  parameter int              PKT_LEN   = 204,
  parameter int              ACQ_COUNT = 3,
  parameter logic [7:0]      DEF_SYNC  = 8'h47
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_byte,
  input  logic       in_valid,
  input  logic [1:0] loss_sel,
  input  logic       prog_sync_en,
  input  logic [7:0] prog_sync_val,
  input  logic       bypass,
  input  logic       irq_clr,
  output logic [7:0] out_byte,
  output logic       out_valid,
  output logic       locked,
  output logic       pkt_start,
  output logic       lock_gain,
  output logic       lock_lost,
  output logic       irq_gain,
  output logic       irq_lost
);
  logic hit, aligned, tracking, restart, gain_evt, lost_evt;
  logic [1:0] irq_vec;

  ts_sync_match #(.DEF_SYNC(DEF_SYNC)) u_match (
    .in_byte(in_byte), .prog_en(prog_sync_en), .prog_val(prog_sync_val), .hit(hit));

  ts_sync_pos #(.PKT_LEN(PKT_LEN)) u_pos (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .restart(restart),
    .tracking(tracking), .aligned(aligned));

  ts_sync_fsm #(.ACQ_COUNT(ACQ_COUNT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hit(hit), .aligned(aligned),
    .bypass(bypass), .loss_sel(loss_sel), .locked(locked), .tracking(tracking),
    .restart(restart), .pkt_start(pkt_start), .gain_evt(gain_evt),
    .lost_evt(lost_evt), .gain_q(lock_gain), .lost_q(lock_lost));

  ts_sync_irq #(.N_EV(2)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev({lost_evt, gain_evt}),
    .ev_q({lock_lost, lock_gain}), .clr(irq_clr), .irq(irq_vec));

  assign irq_gain  = irq_vec[0];
  assign irq_lost  = irq_vec[1];
  assign out_byte  = in_byte;
  assign out_valid = in_valid;

  // R10
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_byte == in_byte) && (out_valid == in_valid));
endmodule

// File: tb/ts_sync_lock_test.sv
`timescale 1ns/1ps
module ts_sync_lock_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] in_byte = 8'h00, prog_sync_val = 8'h00;
  logic in_valid = 1'b0, prog_sync_en = 1'b0, bypass = 1'b0, irq_clr = 1'b0;
  logic [1:0] loss_sel = 2'd3;
  logic [7:0] out_byte;
  logic out_valid, locked, pkt_start, lock_gain, lock_lost, irq_gain, irq_lost;

  int checks = 0, errors = 0, pass_bad = 0, filler_ps = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ts_sync_lock uut (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .loss_sel(loss_sel), .prog_sync_en(prog_sync_en), .prog_sync_val(prog_sync_val),
    .bypass(bypass), .irq_clr(irq_clr), .out_byte(out_byte), .out_valid(out_valid),
    .locked(locked), .pkt_start(pkt_start), .lock_gain(lock_gain),
    .lock_lost(lock_lost), .irq_gain(irq_gain), .irq_lost(irq_lost));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; bypass = 1'b0; irq_clr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One valid byte: pkt_start seen with the byte, state after the edge.
  task automatic send_byte(input logic [7:0] b, output logic ps, output logic lk,
                           output logic g, output logic l);
    @(negedge clk);
    in_byte = b; in_valid = 1'b1;
    #1;
    ps = pkt_start;
    if (out_byte !== b || out_valid !== 1'b1) pass_bad++;
    @(posedge clk); #1;
    lk = locked; g = lock_gain; l = lock_lost;
    in_valid = 1'b0;
  endtask

  // First byte is the candidate sync word, then 203 filler bytes of 0x00.
  task automatic send_pkt(input logic [7:0] first, input int gap,
                          output logic ps, output logic lk, output logic g, output logic l);
    logic p2, k2, g2, l2;
    send_byte(first, ps, lk, g, l);
    for (int i = 1; i < 204; i++) begin
      if (gap > 0 && i == 100) repeat (gap) @(negedge clk);
      send_byte(8'h00, p2, k2, g2, l2);
      if (p2) filler_ps++;
    end
  endtask

  // {good, locked, gain, lost, pkt_start} per packet, loss_sel = 3
  localparam logic [4:0] VEC [18] = '{
    5'b10000, 5'b10000, 5'b11100, 5'b11001, 5'b01001, 5'b01001,
    5'b11001, 5'b01001, 5'b01001, 5'b01001, 5'b01001, 5'b00011,
    5'b10000, 5'b00000, 5'b10000, 5'b10000, 5'b11100, 5'b11001 };

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ps, lk, g, l;
    do_reset();
    #1;
    check(!locked && !lock_gain && !lock_lost, "R7 reset pulses/lock", locked, 0);
    check(!irq_gain && !irq_lost, "R8 reset irq", {irq_lost, irq_gain}, 0);

    // R3 R4 R5 R6 R7 table walk
    foreach (VEC[k]) begin
      send_pkt(VEC[k][4] ? 8'h47 : 8'h12, 0, ps, lk, g, l);
      check(lk == VEC[k][3], $sformatf("R3/R4 locked pkt %0d", k), lk, VEC[k][3]);
      check(g == VEC[k][2], $sformatf("R7 gain pkt %0d", k), g, VEC[k][2]);
      check(l == VEC[k][1], $sformatf("R7 lost pkt %0d", k), l, VEC[k][1]);
      check(ps == VEC[k][0], $sformatf("R6 pkt_start pkt %0d", k), ps, VEC[k][0]);
    end

    // R8 sticky and clear
    @(negedge clk); #1;
    check(irq_gain && irq_lost, "R8 sticky", {irq_lost, irq_gain}, 3);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0; #1;
    check(!irq_gain && !irq_lost, "R8 cleared", {irq_lost, irq_gain}, 0);

    // R4 shortest loss run
    loss_sel = 2'd0; do_reset();
    repeat (3) send_pkt(8'h47, 0, ps, lk, g, l);
    send_pkt(8'h12, 0, ps, lk, g, l);
    check(lk, "R4 sel0 first bad keeps lock", lk, 1);
    send_pkt(8'h12, 0, ps, lk, g, l);
    check(!lk && l, "R4 sel0 second bad loses", {lk, l}, 1);
    loss_sel = 2'd3;

    // R1 inverted default pattern
    do_reset();
    repeat (3) send_pkt(8'hB8, 0, ps, lk, g, l);
    check(lk && g, "R1 inverse 0xB8 locks", {lk, g}, 3);

    // R1 programmed pattern replaces the default
    prog_sync_en = 1'b1; prog_sync_val = 8'h5A; do_reset();
    repeat (3) send_pkt(8'h47, 0, ps, lk, g, l);
    check(!lk, "R1 0x47 ignored when programmed", lk, 0);
    repeat (3) send_pkt(8'h5A, 0, ps, lk, g, l);
    check(lk, "R1 programmed 0x5A locks", lk, 1);
    prog_sync_en = 1'b0;

    // R2 hunt from an offset, with idle gaps inside packets
    do_reset();
    repeat (37) send_byte(8'h00, ps, lk, g, l);
    send_pkt(8'h47, 7, ps, lk, g, l);
    send_pkt(8'h47, 3, ps, lk, g, l);
    send_pkt(8'h47, 5, ps, lk, g, l);
    check(lk && g, "R2 hunt offset with gaps locks", {lk, g}, 3);

    // R9 bypass drops lock silently and blocks detection
    @(negedge clk); bypass = 1'b1;
    @(posedge clk); #1;
    check(!locked && !lock_lost, "R9 bypass drops lock", {locked, lock_lost}, 0);
    repeat (3) begin
      send_pkt(8'h47, 0, ps, lk, g, l);
      check(!lk && !g && !ps, "R9 no detection in bypass", {lk, g, ps}, 0);
    end
    #1;
    check(!irq_lost, "R9 no lost irq", irq_lost, 0);
    bypass = 1'b0;

    check(filler_ps == 0, "R6 no pkt_start on filler", filler_ps, 0);
    check(pass_bad == 0, "R10 passthrough", pass_bad, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule